// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Sequencer

This block runs the entry sequence of a non-maskable interrupt inside an 8-bit accumulator CPU core. The core raises `boundary` in the cycle between two instructions, before the next opcode fetch. If `nmi_req` is also high in that cycle and the sequencer is idle, the sequencer captures the live PC, SP and status values. It stores the return address and a tagged copy of the status byte on the descending stack in page one. It then reads the handler address from the fixed vector pair.

When the sequence finishes, the block presents the new PC, the new SP and the new status value for one clock on `done`. On that same clock it acknowledges the request and reports the extra bus cycles that the core must add to its cycle counter. The memory port is single ported. Read data returns one clock after a read strobe.

Top module: `nmi_entry_seq`

## Requirements
- R1: A sequence starts only on a rising clock edge where `boundary` and `nmi_req` are both high and `busy` is low. At any other time the block drives no memory strobe and `busy` stays low.
- R2: The first write stores PC[15:8] at 0x0100+SP and the second write stores PC[7:0] at 0x0100+((SP-1) mod 256). Both values are the ones captured at the start edge, and every write address lies in page one (address bits [15:8] equal 0x01).
- R3: The third write goes to 0x0100+((SP-2) mod 256) and carries the captured status byte with bit 4 forced to 0, bit 5 forced to 1, and every other bit unchanged.
- R4: `sp_new` equals the captured SP minus 3, modulo 256.
- R5: After the three writes come two reads, first from 0xFFFA and then from 0xFFFB. `pc_new` equals {byte read at 0xFFFB, byte read at 0xFFFA}.
- R6: `p_new` equals the captured status with bit 2 (interrupt disable) set. Bits 4 and 5 of `p_new` equal those of the captured status.
- R7: `done` and `nmi_ack` are high together for exactly one clock, in the 7th cycle after the start edge. `cyc_add` equals 2 in that cycle and 0 in every other cycle.
- R8: While a sequence runs, further requests are ignored: it makes exactly three writes and two reads and gives one `done` pulse. `mem_wr` and `mem_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Core is between instructions |
| nmi_req | input | 1 | Pending non-maskable interrupt |
| pc_in | input | 16 | Live program counter |
| sp_in | input | 8 | Live stack pointer |
| p_in | input | 8 | Live status register |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe; data returns one clock later |
| mem_rdata | input | 8 | Memory read data |
| pc_new | output | 16 | Handler address, valid with done |
| sp_new | output | 8 | Stack pointer after the pushes, valid with done |
| p_new | output | 8 | Status with interrupt disable set, valid with done |
| cyc_add | output | 4 | Extra cycles to charge, nonzero only with done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| nmi_ack | output | 1 | Request acknowledge, with done |

## Verification
Two situations are the hardest to reach from the ports. One is a request that arrives again while a sequence is already running. The other is a stack pointer that wraps within page one partway through the pushes. The random trials keep `boundary` and `nmi_req` high through the middle of many sequences, and the bench then checks that there is still only one write triple, one read pair and one `done` pulse. Directed trials start with SP at 0x01 and at 0x00 so that the wrap falls on the third write and on the second write.

// File: rtl/nmi_entry_pkg.sv
// Shared types and bit positions for the interrupt entry sequencer.
// Assumes an 8-bit status register with the usual flag layout.
package nmi_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_H  = 3'd1,
        ST_PUSH_L  = 3'd2,
        ST_PUSH_P  = 3'd3,
        ST_FETCH_L = 3'd4,
        ST_FETCH_H = 3'd5,
        ST_LOAD    = 3'd6
    } seq_state_t;

    localparam int IDIS_BIT  = 2;
    localparam int BRK_BIT   = 4;
    localparam int SPARE_BIT = 5;
endpackage

// File: rtl/nmi_seq_ctrl.sv
// Step controller: walks through the pushes, the vector reads and the load.
// Assumes start is only asserted in ST_IDLE. Done is registered, one clock.
module nmi_seq_ctrl
    import nmi_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_t state,
    output logic       done_o
);
    seq_state_t nxt;

    // Next-step selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    nxt = start ? ST_PUSH_H : ST_IDLE;
            ST_PUSH_H:  nxt = ST_PUSH_L;
            ST_PUSH_L:  nxt = ST_PUSH_P;
            ST_PUSH_P:  nxt = ST_FETCH_L;
            ST_FETCH_L: nxt = ST_FETCH_H;
            ST_FETCH_H: nxt = ST_LOAD;
            ST_LOAD:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State and completion-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_o <= 1'b0;
        end else begin
            state  <= nxt;
            done_o <= (state == ST_LOAD);
        end
    end
endmodule

// File: rtl/nmi_stack_ptr.sv
// Stack pointer copy: loaded at start, decremented after each push.
// Assumes the stack is a single page at STACK_BASE; SP wraps in SP_W bits.
module nmi_stack_ptr #(
    parameter int               ADDR_W     = 16,
    parameter int               SP_W       = 8,
    parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SP_W-1:0]   load_val,
    input  logic              dec,
    output logic [SP_W-1:0]   sp_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - SP_W;

    // Pointer register with modulo decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_o <= '0;
        else if (load) sp_o <= load_val;
        else if (dec)  sp_o <= sp_o - 1'b1;
    end

    // Address of the current stack slot.
    always_comb addr_o = STACK_BASE | {{PAD_W{1'b0}}, sp_o};
endmodule

// File: rtl/nmi_status_fmt.sv
// Status formatting: makes the pushed copy and the post-entry live value.
// Purely combinational; the bit positions come from the package.
module nmi_status_fmt
    import nmi_entry_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] p_i,
    output logic [DATA_W-1:0] push_o,
    output logic [DATA_W-1:0] masked_o
);
    // Pushed copy: break clear, spare set. Live copy: interrupt disable set.
    always_comb begin
        push_o            = p_i;
        push_o[BRK_BIT]   = 1'b0;
        push_o[SPARE_BIT] = 1'b1;
        masked_o          = p_i;
        masked_o[IDIS_BIT] = 1'b1;
    end
endmodule

// File: rtl/nmi_entry_seq.sv
// Interrupt entry sequencer top. It samples a request at an instruction
// boundary, pushes PC (high, then low) and the tagged status, then reads the
// vector pair, and reports the new PC, SP and status with a done pulse.
// Assumes read data returns one clock after mem_rd and ADDR_W == 2*DATA_W.
module nmi_entry_seq
    import nmi_entry_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                ADDR_W     = 16,
    parameter int                SP_W       = 8,
    parameter int                CYC_W      = 4,
    parameter int                EXTRA_CYC  = 2,
    parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] p_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_new,
    output logic [SP_W-1:0]   sp_new,
    output logic [DATA_W-1:0] p_new,
    output logic [CYC_W-1:0]  cyc_add,
    output logic              busy,
    output logic              done,
    output logic              nmi_ack
);
    localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + 1'b1;

    seq_state_t        state;
    logic              start;
    logic              push_step;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] p_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] p_push;
    logic [DATA_W-1:0] p_masked;
    logic [ADDR_W-1:0] stk_addr;

    // Request sampling at the boundary while idle.
    always_comb start = (state == ST_IDLE) && boundary && nmi_req;
    always_comb push_step = (state == ST_PUSH_H) || (state == ST_PUSH_L) ||
                            (state == ST_PUSH_P);

    nmi_seq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .done_o (done)
    );

    nmi_stack_ptr #(
        .ADDR_W     (ADDR_W),
        .SP_W       (SP_W),
        .STACK_BASE (STACK_BASE)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (sp_in),
        .dec      (push_step),
        .sp_o     (sp_new),
        .addr_o   (stk_addr)
    );

    nmi_status_fmt #(.DATA_W(DATA_W)) u_fmt (
        .p_i      (p_q),
        .push_o   (p_push),
        .masked_o (p_masked)
    );

    // Captured PC/status, vector low byte and final PC load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            p_q  <= '0;
            lo_q <= '0;
        end else begin
            if (start) begin
                pc_q <= pc_in;
                p_q  <= p_in;
            end
            if (state == ST_PUSH_P)  p_q  <= p_masked;
            if (state == ST_FETCH_H) lo_q <= mem_rdata;
            if (state == ST_LOAD)    pc_q <= {mem_rdata, lo_q};
        end
    end

    // Memory port drive for each step.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        case (state)
            ST_PUSH_H: begin
                mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = pc_q[ADDR_W-1:DATA_W];
            end
            ST_PUSH_L: begin
                mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_P: begin
                mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = p_push;
            end
            ST_FETCH_L: begin
                mem_rd = 1'b1; mem_addr = VEC_ADDR;
            end
            ST_FETCH_H: begin
                mem_rd = 1'b1; mem_addr = VEC_HI;
            end
            default: ;
        endcase
    end

    // Result and handshake outputs.
    always_comb begin
        pc_new  = pc_q;
        p_new   = p_q;
        busy    = (state != ST_IDLE);
        nmi_ack = done;
        cyc_add = done ? CYC_W'(EXTRA_CYC) : '0;
    end
endmodule

// File: rtl/nmi_entry_seq_chk.sv
// Property checker for the entry sequencer, attached by bind.
module nmi_entry_seq_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              nmi_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [DATA_W-1:0] p_new,
    input logic              busy,
    input logic              done
);
    // R1: a sequence only begins from a sampled request at a boundary.
    assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(boundary && nmi_req));
    // R1: no memory traffic while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_wr && !mem_rd));
    // R2: every write lands in page one.
    assert_page_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[ADDR_W-1:8] == 8'h01));
    // R6: interrupt disable set whenever results are presented.
    assert_idis_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> p_new[2]);
    // R7: completion is a single-clock pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: read and write never share a cycle.
    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));
endmodule

bind nmi_entry_seq nmi_entry_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .nmi_req  (nmi_req),
    .mem_addr (mem_addr),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .p_new    (p_new),
    .busy     (busy),
    .done     (done)
);

// File: tb/nmi_entry_seq_tb.sv
module nmi_entry_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        nmi_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  p_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_wr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] pc_new;
    logic [7:0]  sp_new;
    logic [7:0]  p_new;
    logic [3:0]  cyc_add;
    logic        busy;
    logic        done;
    logic        nmi_ack;

    int checks = 0;
    int errs = 0;
    logic [7:0]  vec_lo = '0;
    logic [7:0]  vec_hi = '0;
    logic [15:0] wa [0:7];
    logic [7:0]  wd [0:7];
    logic [15:0] ra [0:7];
    int wn = 0;
    int rn = 0;

    always #(CLK_P/2) clk = ~clk;

    nmi_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
        .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .pc_new(pc_new),
        .sp_new(sp_new), .p_new(p_new), .cyc_add(cyc_add), .busy(busy),
        .done(done), .nmi_ack(nmi_ack)
    );

    // Memory model: logs accesses, returns vector bytes one clock after a read.
    always @(posedge clk) begin
        if (mem_wr && wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; wn = wn + 1; end
        if (mem_rd) begin
            if (rn < 8) begin ra[rn] = mem_addr; rn = rn + 1; end
            mem_rdata <= (mem_addr == 16'hFFFA) ? vec_lo :
                         (mem_addr == 16'hFFFB) ? vec_hi : 8'hEE;
        end
    end

    function automatic logic [7:0] exp_push(input logic [7:0] p);
        return (p & 8'hEF) | 8'h20;
    endfunction
    function automatic logic [7:0] exp_live(input logic [7:0] p);
        return p | 8'h04;
    endfunction
    function automatic logic [15:0] slot(input logic [7:0] sp, input int k);
        logic [7:0] s;
        s = sp - 8'(k);
        return {8'h01, s};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    endtask

    // One sequence; noisy keeps the request raised during the sequence (R8).
    task automatic trial(input logic [15:0] pc, input logic [7:0] sp,
                         input logic [7:0] p, input logic [7:0] lo,
                         input logic [7:0] hi, input bit noisy);
        @(negedge clk);
        wn = 0; rn = 0;
        pc_in = pc; sp_in = sp; p_in = p; vec_lo = lo; vec_hi = hi;
        boundary = 1'b1; nmi_req = 1'b1;
        @(posedge clk);
        for (int c = 1; c <= 7; c++) begin
            @(negedge clk);
            boundary = noisy && (c < 5);
            nmi_req  = noisy && (c < 5);
            if (c < 7) chk(!done && cyc_add == 0, "R7 early done", {done, cyc_add}, 0);
        end
        chk(done && nmi_ack, "R7 done/ack", {done, nmi_ack}, 2'b11);
        chk(cyc_add == 4'd2, "R7 cyc_add", cyc_add, 2);
        chk(pc_new == {hi, lo}, "R5 pc_new", pc_new, {hi, lo});
        chk(sp_new == 8'(sp - 8'd3), "R4 sp_new", sp_new, 8'(sp - 8'd3));
        chk(p_new == exp_live(p), "R6 p_new", p_new, exp_live(p));
        @(negedge clk);
        chk(!done && cyc_add == 0, "R7 single pulse", done, 0);
        chk(wn == 3 && rn == 2, "R8 access count", {wn[7:0], rn[7:0]}, 16'h0302);
        chk(wa[0] == slot(sp, 0) && wd[0] == pc[15:8], "R2 push high",
            {wa[0], wd[0]}, {slot(sp, 0), pc[15:8]});
        chk(wa[1] == slot(sp, 1) && wd[1] == pc[7:0], "R2 push low",
            {wa[1], wd[1]}, {slot(sp, 1), pc[7:0]});
        chk(wa[2] == slot(sp, 2) && wd[2] == exp_push(p), "R3 push status",
            {wa[2], wd[2]}, {slot(sp, 2), exp_push(p)});
        chk(ra[0] == 16'hFFFA && ra[1] == 16'hFFFB, "R5 read order",
            {ra[0], ra[1]}, 32'hFFFAFFFB);
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; errs++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !done && !mem_wr && !mem_rd && cyc_add == 0, "R7 reset state",
            {busy, done, mem_wr, mem_rd}, 0);

        // R1: request without boundary, and boundary without request.
        wn = 0; rn = 0;
        nmi_req = 1'b1; boundary = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && wn == 0 && rn == 0, "R1 no boundary", {busy, wn[7:0]}, 0);
        nmi_req = 1'b0; boundary = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy && wn == 0 && rn == 0, "R1 no request", {busy, wn[7:0]}, 0);
        boundary = 1'b0;

        // Directed: wrap on third and second push, break bits set in live status.
        trial(16'hC123, 8'h01, 8'hFF, 8'h34, 8'h12, 1'b0);
        trial(16'h8000, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1);
        trial(16'hFFFF, 8'hFD, 8'h30, 8'hAB, 8'hCD, 1'b0);

        for (int i = 0; i < 40; i++) begin
            trial(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  8'($urandom), 1'($urandom));
            repeat (int'($urandom % 3)) @(negedge clk);
        end
        finish_run();
    end
endmodule